// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the clock-control state of a processor core. The core moves between a running state, a halted state, a clock-stop grant, a snoop window, sleep and deep sleep. It reads level requests (halt, stop-clock, sleep, soft reset), snoop activity, a bus-clock-running indication and five interrupt sources. From these it reports the current state as a small code, enables for the core and cache clock domains, whether snoops and interrupts are accepted, and one-cycle pulses for interrupts that were parked while clocks were stopped.

All request inputs cross two flip-flops before the state logic uses them. The snoop window remembers which low-power state it interrupted and returns there. The clock-stop grant remembers whether it was entered from running or from halt. Deep sleep is left only after the restarted bus clock has been running for a programmable settle count. At 100 MHz, one millisecond is 100000 cycles.

Top module: `lp_state_ctrl`

## Requirements
- R1: After rst_n deasserts, state_code reads 1 (running), core_clk_en and cache_clk_en are 1, and pend_pulse and snoop_err are 0.
- R2: State codes are 1 running, 2 halted, 3 grant, 4 snoop, 5 sleep, 6 deep sleep, and no other value appears. In running, halt moves to halted (stop-clock takes priority). In halted, any of SMI, INIT, bus-init, NMI or INTR returns to running.
- R3: Stop-clock in running or halted enters grant. Releasing stop-clock in grant returns to the state grant was entered from.
- R4: snoop_act in halted or grant enters snoop (in grant, snoop wins over sleep). A snoop_done pulse in snoop returns to the exact state the snoop interrupted.
- R5: The sleep request has no effect in running or halted. In grant it enters sleep, and releasing it in sleep returns to grant. Sleep is only ever entered from grant or deep sleep.
- R6: In grant, SMI, INIT, NMI and INTR are recorded. On the first cycle in running after any other state, pend_pulse shows each recorded source exactly once, however often it was asserted. The bits are 0 SMI, 1 INIT, 2 NMI, 3 INTR. Pulses appear only in that cycle.
- R7: bclk_run low in sleep enters deep sleep. Once the synchronized bclk_run is high, deep sleep holds for SETTLE_CYC cycles, so sleep is reported SETTLE_CYC+2 rising edges after bclk_run rises. A drop of bclk_run restarts the count.
- R8: snoop_ok and irq_accept are 0 in sleep and deep sleep. snoop_act seen in either state yields a one-cycle snoop_err pulse per synchronized cycle.
- R9: req_reset forces running from any state, sleep included, and clears recorded interrupts.
- R10: Bus-init in grant leaves the block in grant while stop-clock stays asserted. If stop-clock is released at the same time, the block goes to running, even when grant was entered from halted.
- R11: Every request input passes two flops. A change driven between edges first affects state on the third rising edge.
- R12: core_clk_en is 1 only in running. cache_clk_en and snoop_ok are 1 in running, halted, grant and snoop. irq_accept is 1 in running and halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_halt | input | 1 | Halt request level |
| req_stopclk | input | 1 | Stop-clock request level |
| req_sleep | input | 1 | Sleep request level |
| req_reset | input | 1 | Soft reset request |
| snoop_act | input | 1 | Snoop transaction in progress |
| snoop_done | input | 1 | Snoop serviced pulse |
| bclk_run | input | 1 | Bus clock running indication |
| irq_smi | input | 1 | System management interrupt |
| irq_init | input | 1 | Init interrupt |
| irq_binit | input | 1 | Bus-init event |
| irq_nmi | input | 1 | Non-maskable interrupt |
| irq_intr | input | 1 | Maskable interrupt |
| state_code | output | 3 | Current state, 1 to 6 |
| core_clk_en | output | 1 | Core clock enable |
| cache_clk_en | output | 1 | Cache/snoop clock enable |
| snoop_ok | output | 1 | Snoops are accepted |
| irq_accept | output | 1 | Interrupts are accepted |
| pend_pulse | output | 4 | Released recorded interrupts |
| snoop_err | output | 1 | Snoop seen while asleep |

## Verification
The assertions assume that snoop_done arrives only to close a snoop window. They also assume that any pulse on a request lasts at least one full clock, so it survives the two-flop synchronizer. The random stimulus flips inputs between edges with a fixed seed and makes snoop_done a single-cycle pulse. Soft reset and snoop-in-sleep are deliberately allowed to occur, because the block has defined responses to both.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd1,
    ST_HALT  = 3'd2,
    ST_GRANT = 3'd3,
    ST_SNOOP = 3'd4,
    ST_SLEEP = 3'd5,
    ST_DEEP  = 3'd6
  } lp_state_e;

  localparam int REQ_W    = 12;
  localparam int PEND_W   = 4;
  localparam int IX_HALT  = 0;
  localparam int IX_STOP  = 1;
  localparam int IX_SLEEP = 2;
  localparam int IX_RST   = 3;
  localparam int IX_SNA   = 4;
  localparam int IX_SND   = 5;
  localparam int IX_BCLK  = 6;
  localparam int IX_SMI   = 7;
  localparam int IX_INIT  = 8;
  localparam int IX_BINIT = 9;
  localparam int IX_NMI   = 10;
  localparam int IX_INTR  = 11;

  function automatic logic core_clock_on(lp_state_e s);
    return s == ST_RUN;
  endfunction

  function automatic logic cache_clock_on(lp_state_e s);
    return (s == ST_RUN) || (s == ST_HALT) || (s == ST_GRANT) || (s == ST_SNOOP);
  endfunction

  function automatic logic accepts_irq(lp_state_e s);
    return (s == ST_RUN) || (s == ST_HALT);
  endfunction

  function automatic logic bus_quiet(lp_state_e s);
    return (s == ST_SLEEP) || (s == ST_DEEP);
  endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/lp_settle.sv
module lp_settle #(
  parameter int LIMIT = 100000,
  parameter int CNT_W = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (done)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/lp_pend.sv
module lp_pend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         latch_en,
  input  logic         release_now,
  input  logic [N-1:0] src,
  output logic [N-1:0] pulse
);
  logic [N-1:0] flag_q;
  logic [N-1:0] pulse_q;
  logic [N-1:0] seen;

  assign seen = latch_en ? src : '0;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i]  <= 1'b0;
        pulse_q[i] <= 1'b0;
      end else if (clr) begin
        flag_q[i]  <= 1'b0;
        pulse_q[i] <= 1'b0;
      end else if (release_now) begin
        flag_q[i]  <= 1'b0;
        pulse_q[i] <= flag_q[i] | seen[i];
      end else begin
        flag_q[i]  <= flag_q[i] | seen[i];
        pulse_q[i] <= 1'b0;
      end
    end
  end

  assign pulse = pulse_q;

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |=> (pulse_q == '0));
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl #(
  parameter int SETTLE_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_halt,
  input  logic       req_stopclk,
  input  logic       req_sleep,
  input  logic       req_reset,
  input  logic       snoop_act,
  input  logic       snoop_done,
  input  logic       bclk_run,
  input  logic       irq_smi,
  input  logic       irq_init,
  input  logic       irq_binit,
  input  logic       irq_nmi,
  input  logic       irq_intr,
  output logic [2:0] state_code,
  output logic       core_clk_en,
  output logic       cache_clk_en,
  output logic       snoop_ok,
  output logic       irq_accept,
  output logic [3:0] pend_pulse,
  output logic       snoop_err
);
  import lp_pkg::*;

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [REQ_W-1:0] raw_req;
  logic [REQ_W-1:0] s_req;

  assign raw_req[IX_HALT]  = req_halt;
  assign raw_req[IX_STOP]  = req_stopclk;
  assign raw_req[IX_SLEEP] = req_sleep;
  assign raw_req[IX_RST]   = req_reset;
  assign raw_req[IX_SNA]   = snoop_act;
  assign raw_req[IX_SND]   = snoop_done;
  assign raw_req[IX_BCLK]  = bclk_run;
  assign raw_req[IX_SMI]   = irq_smi;
  assign raw_req[IX_INIT]  = irq_init;
  assign raw_req[IX_BINIT] = irq_binit;
  assign raw_req[IX_NMI]   = irq_nmi;
  assign raw_req[IX_INTR]  = irq_intr;

  lp_sync #(.W(REQ_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_req), .q(s_req)
  );

  // Named synchronized events, visible to the assertions
  logic s_halt, s_stop, s_sleep, s_rst, s_snoop, s_done, s_bclk;
  logic s_binit, any_wake;
  logic [PEND_W-1:0] park_src;

  assign s_halt   = s_req[IX_HALT];
  assign s_stop   = s_req[IX_STOP];
  assign s_sleep  = s_req[IX_SLEEP];
  assign s_rst    = s_req[IX_RST];
  assign s_snoop  = s_req[IX_SNA];
  assign s_done   = s_req[IX_SND];
  assign s_bclk   = s_req[IX_BCLK];
  assign s_binit  = s_req[IX_BINIT];
  assign park_src = {s_req[IX_INTR], s_req[IX_NMI], s_req[IX_INIT], s_req[IX_SMI]};
  assign any_wake = s_binit | (|park_src);

  lp_state_e state_q, nxt, origin_q, ret_q;
  logic      settle_run, settle_done;
  logic      release_now;
  logic      err_q;

  assign settle_run = (state_q == ST_DEEP) && s_bclk;

  lp_settle #(.LIMIT(SETTLE_CYC), .CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(settle_run), .done(settle_done)
  );

  always_comb begin
    nxt = state_q;
    if (s_rst) begin
      nxt = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (s_stop)      nxt = ST_GRANT;
          else if (s_halt) nxt = ST_HALT;
        end
        ST_HALT: begin
          if (any_wake)     nxt = ST_RUN;
          else if (s_stop)  nxt = ST_GRANT;
          else if (s_snoop) nxt = ST_SNOOP;
        end
        ST_GRANT: begin
          if (!s_stop)      nxt = s_binit ? ST_RUN : origin_q;
          else if (s_snoop) nxt = ST_SNOOP;
          else if (s_sleep) nxt = ST_SLEEP;
        end
        ST_SNOOP: begin
          if (s_done) nxt = ret_q;
        end
        ST_SLEEP: begin
          if (!s_sleep)     nxt = ST_GRANT;
          else if (!s_bclk) nxt = ST_DEEP;
        end
        ST_DEEP: begin
          if (settle_done) nxt = ST_SLEEP;
        end
        default: nxt = ST_RUN;
      endcase
    end
  end

  assign release_now = !s_rst && (nxt == ST_RUN) && (state_q != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      origin_q <= ST_RUN;
      ret_q    <= ST_GRANT;
      err_q    <= 1'b0;
    end else begin
      state_q <= nxt;
      err_q   <= bus_quiet(state_q) && s_snoop;
      if (!s_rst && nxt == ST_GRANT &&
          (state_q == ST_RUN || state_q == ST_HALT))
        origin_q <= state_q;
      if (!s_rst && nxt == ST_SNOOP && state_q != ST_SNOOP)
        ret_q <= state_q;
    end
  end

  lp_pend #(.N(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(s_rst),
    .latch_en(state_q == ST_GRANT), .release_now(release_now),
    .src(park_src), .pulse(pend_pulse)
  );

  assign state_code   = state_q;
  assign core_clk_en  = core_clock_on(state_q);
  assign cache_clk_en = cache_clock_on(state_q);
  assign snoop_ok     = cache_clock_on(state_q);
  assign irq_accept   = accepts_irq(state_q);
  assign snoop_err    = err_q;

  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code >= 3'd1) && (state_code <= 3'd6));

  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |->
      ($past(state_q) == ST_GRANT || $past(state_q) == ST_DEEP));

  // R7
  deep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_DEEP && state_q != ST_DEEP) |->
      ($past(settle_done) || $past(s_rst)));

  // R4
  snoop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SNOOP && state_q != ST_SNOOP) |->
      ($past(s_done) || $past(s_rst)));

  // R6
  pend_when_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_pulse != '0) |-> (state_q == ST_RUN && $past(state_q) != ST_RUN));

  // R8
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_quiet(state_q) |-> (!snoop_ok && !irq_accept && !core_clk_en));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rst |=> (state_q == ST_RUN && pend_pulse == '0));
endmodule

// File: tb/lp_state_ctrl_tb.sv
module lp_state_ctrl_tb_top;
  localparam int SET = 20;
  localparam logic [11:0] B_HALT = 12'h001, B_STP = 12'h002, B_SLP = 12'h004,
                          B_RST = 12'h008, B_SNA = 12'h010, B_SND = 12'h020,
                          B_BCLK = 12'h040, B_SMI = 12'h080, B_INIT = 12'h100,
                          B_BINIT = 12'h200, B_NMI = 12'h400, B_INTR = 12'h800;
  localparam logic [11:0] IDLE = B_BCLK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] in_vec = IDLE;
  logic [2:0] state_code;
  logic core_clk_en, cache_clk_en, snoop_ok, irq_accept, snoop_err;
  logic [3:0] pend_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lp_state_ctrl #(.SETTLE_CYC(SET)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_halt(in_vec[0]), .req_stopclk(in_vec[1]), .req_sleep(in_vec[2]),
    .req_reset(in_vec[3]), .snoop_act(in_vec[4]), .snoop_done(in_vec[5]),
    .bclk_run(in_vec[6]), .irq_smi(in_vec[7]), .irq_init(in_vec[8]),
    .irq_binit(in_vec[9]), .irq_nmi(in_vec[10]), .irq_intr(in_vec[11]),
    .state_code(state_code), .core_clk_en(core_clk_en), .cache_clk_en(cache_clk_en),
    .snoop_ok(snoop_ok), .irq_accept(irq_accept), .pend_pulse(pend_pulse),
    .snoop_err(snoop_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements
  logic [11:0] p1, p2;
  int m_st, m_org, m_ret, m_cnt, m_err;
  logic [3:0] m_flags, m_pulse;

  function automatic int exp_core(int s);  return (s == 1) ? 1 : 0; endfunction
  function automatic int exp_cache(int s); return (s >= 1 && s <= 4) ? 1 : 0; endfunction
  function automatic int exp_irq(int s);   return (s == 1 || s == 2) ? 1 : 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = '0; p2 = '0; m_st = 1; m_org = 1; m_ret = 3; m_cnt = 0;
      m_flags = '0; m_pulse = '0; m_err = 0;
    end else begin
      int ns;
      logic [3:0] seen, nf;
      ns = m_st;
      seen = (m_st == 3) ? {p2[11], p2[10], p2[8], p2[7]} : 4'h0;
      m_err = ((m_st == 5 || m_st == 6) && p2[4]) ? 1 : 0;
      m_pulse = '0;
      if (p2[3]) begin
        ns = 1; m_flags = '0; m_cnt = 0;
      end else begin
        case (m_st)
          1: if (p2[1]) begin ns = 3; m_org = 1; end else if (p2[0]) ns = 2;
          2: if (p2[7] | p2[8] | p2[9] | p2[10] | p2[11]) ns = 1;
             else if (p2[1]) begin ns = 3; m_org = 2; end
             else if (p2[4]) begin ns = 4; m_ret = 2; end
          3: if (!p2[1]) ns = p2[9] ? 1 : m_org;
             else if (p2[4]) begin ns = 4; m_ret = 3; end
             else if (p2[2]) ns = 5;
          4: if (p2[5]) ns = m_ret;
          5: if (!p2[2]) ns = 3; else if (!p2[6]) ns = 6;
          default: ;
        endcase
        if (m_st == 6) begin
          if (!p2[6]) m_cnt = 0;
          else if (m_cnt == SET - 1) begin ns = 5; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
        nf = m_flags | seen;
        if (ns == 1 && m_st != 1) begin m_pulse = nf; m_flags = '0; end
        else m_flags = nf;
      end
      m_st = ns;
      p2 = p1; p1 = in_vec;
    end
  end

  // Continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "state_code", state_code, m_st);
      chk("R12", "core_clk_en", core_clk_en, exp_core(m_st));
      chk("R12", "cache_clk_en", cache_clk_en, exp_cache(m_st));
      chk("R8", "irq_accept", irq_accept, exp_irq(m_st));
      chk("R6", "pend_pulse", pend_pulse, m_pulse);
      chk("R8", "snoop_err", snoop_err, m_err);
    end
  end

  // Pulse counters for directed windows
  int cnt_p[4];
  int cnt_err;
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) if (pend_pulse[i]) cnt_p[i]++;
    if (snoop_err) cnt_err++;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic drive(logic [11:0] v); #1 in_vec = v; endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    tick(3);
    drive(IDLE);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "state after reset", state_code, 1);
    chk("R1", "core_clk_en after reset", core_clk_en, 1);
    chk("R1", "pend_pulse after reset", pend_pulse, 0);

    // Constrained random phase
    for (int c = 0; c < 6000; c++) begin
      logic [11:0] v;
      int r;
      v = in_vec & ~B_SND;
      r = $urandom % 48;
      if (r < 12) begin
        if (r == 3) begin
          if ($urandom % 10 == 0) v[3] = 1'b1;
        end else v[r] = ~v[r];
      end
      if (v[3] && ($urandom % 2 == 0)) v[3] = 1'b0;
      drive(v);
      tick(1);
    end

    // Directed corner cases
    drive(IDLE);
    rst_n = 1'b0;
    tick(3);
    drive(IDLE);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "state after second reset", state_code, 1);

    drive(IDLE | B_HALT);
    tick(2);
    chk("R11", "state two edges after halt", state_code, 1);
    tick(1);
    chk("R11", "state three edges after halt", state_code, 2);

    drive(IDLE | B_NMI); tick(4);
    chk("R2", "NMI wakes halted", state_code, 1);
    drive(IDLE); tick(2);

    drive(IDLE | B_SLP); tick(5);
    chk("R5", "sleep ignored in running", state_code, 1);
    drive(IDLE | B_SLP | B_HALT); tick(5);
    chk("R5", "sleep ignored in halted", state_code, 2);

    drive(IDLE | B_HALT | B_STP); tick(5);
    chk("R3", "grant from halted", state_code, 3);
    chk("R12", "core clock off in grant", core_clk_en, 0);
    drive(IDLE); tick(5);
    chk("R3", "grant returns to halted", state_code, 2);
    drive(IDLE | B_INTR); tick(4);
    chk("R2", "INTR wakes halted", state_code, 1);
    drive(IDLE); tick(2);

    drive(IDLE | B_HALT); tick(4);
    drive(IDLE | B_HALT | B_SNA); tick(4);
    chk("R4", "snoop from halted", state_code, 4);
    drive(IDLE | B_HALT | B_SND); tick(1);
    drive(IDLE | B_HALT); tick(4);
    chk("R4", "snoop returns to halted", state_code, 2);
    drive(IDLE | B_HALT | B_STP); tick(4);
    drive(IDLE | B_HALT | B_STP | B_SNA); tick(4);
    chk("R4", "snoop from grant", state_code, 4);
    drive(IDLE | B_HALT | B_STP | B_SND); tick(1);
    drive(IDLE | B_HALT | B_STP); tick(4);
    chk("R4", "snoop returns to grant", state_code, 3);

    for (int i = 0; i < 4; i++) cnt_p[i] = 0;
    for (int k = 0; k < 3; k++) begin
      drive(IDLE | B_HALT | B_STP | B_SMI); tick(2);
      drive(IDLE | B_HALT | B_STP); tick(2);
    end
    drive(IDLE | B_HALT | B_STP | B_NMI); tick(2);
    drive(IDLE | B_HALT | B_STP); tick(3);
    chk("R6", "no pulse while parked", cnt_p[0] + cnt_p[2], 0);
    drive(IDLE); tick(5);
    chk("R6", "parked flags kept in halted", state_code, 2);
    drive(IDLE | B_INIT); tick(4);
    drive(IDLE); tick(6);
    chk("R6", "SMI pulses once", cnt_p[0], 1);
    chk("R6", "INIT not parked outside grant", cnt_p[1], 0);
    chk("R6", "NMI pulses once", cnt_p[2], 1);
    chk("R6", "INTR never parked", cnt_p[3], 0);

    drive(IDLE | B_STP); tick(4);
    drive(IDLE | B_STP | B_BINIT); tick(4);
    chk("R10", "bus-init with stop-clock held", state_code, 3);
    drive(IDLE); tick(4);
    drive(IDLE | B_HALT); tick(4);
    drive(IDLE | B_HALT | B_STP); tick(4);
    chk("R3", "grant entered from halted", state_code, 3);
    drive(IDLE | B_BINIT); tick(4);
    chk("R10", "bus-init releases to running", state_code, 1);
    drive(IDLE); tick(3);

    drive(IDLE | B_STP); tick(4);
    drive(IDLE | B_STP | B_SLP); tick(4);
    chk("R5", "sleep from grant", state_code, 5);
    chk("R8", "snoop_ok low in sleep", snoop_ok, 0);
    chk("R8", "irq_accept low in sleep", irq_accept, 0);
    cnt_err = 0;
    drive(IDLE | B_STP | B_SLP | B_SNA); tick(1);
    drive(IDLE | B_STP | B_SLP); tick(4);
    chk("R8", "one error pulse per snoop cycle", cnt_err, 1);
    drive(IDLE | B_STP); tick(4);
    chk("R5", "sleep release returns to grant", state_code, 3);
    drive(IDLE | B_STP | B_SLP); tick(4);
    drive(B_STP | B_SLP); tick(4);
    chk("R7", "bus clock stop enters deep", state_code, 6);
    drive(IDLE | B_STP | B_SLP);
    tick(SET + 1);
    chk("R7", "still deep during settle", state_code, 6);
    tick(1);
    chk("R7", "sleep after settle", state_code, 5);
    drive(IDLE | B_STP | B_SLP | B_RST); tick(4);
    chk("R9", "soft reset from sleep", state_code, 1);
    drive(IDLE); tick(4);
    chk("R9", "running after soft reset", state_code, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule